// File: doc/BRIEF.md
# Link alert response controller

This block reacts to a damaged or deliberately flagged southbound frame on a frame-based serial memory link. When a frame arrives with a bad CRC, or with the software injection trigger raised while injection is enabled, the command it carries is dropped. The full raw frame is kept in a log, the error kind is recorded, and an alert status bit is raised. From then on the block acts as a command gate that lets through one command type only, the soft channel reset, and it steers the northbound path to idle frames and then to a continuous stream of alert frames.

One decoded frame is presented per clock, so one clock is one frame slot. The first alert frame is placed in the slot where the reply to a configuration read would have appeared, a fixed number of slots after the bad frame. A soft channel reset or a link fast reset ends the alert state. The error flags and the log are kept until an explicit clear. Frame encoding and serialization are handled elsewhere.

Top module: `lnk_alert_ctl`

## Requirements
- R1: An injection trigger on a frame counts as an error only while the injection mask bit is 1. With the bit at 0, a good-CRC frame carrying the trigger executes (cmd_exec high) and sets no flag.
- R2: A frame that has a CRC error with the CRC mask bit at 1, or an enabled injection, is not executed: cmd_exec is low in the cycle it is presented. A frame with a bad CRC never executes.
- R3: The full FRAME_W-bit frame of the first error is captured in log_frame one cycle later. It is held unchanged while err_first is nonzero, and later errors do not overwrite it.
- R4: Error kinds use bit 0 for a CRC error and bit 1 for an injected alert. The first error's kinds go to err_first. Errors while err_first is nonzero are ORed into err_next. Any error sets alert_stat. A pulse on err_clr clears err_first, err_next and alert_stat.
- R5: While nb_sel is not 0, only frames with command code 3 (soft channel reset) execute. Codes 0 (no-op), 1 (configuration read) and 2 (other command) are blocked.
- R6: nb_sel uses 0 for normal traffic, 1 for an idle frame and 2 for an alert frame. After an error frame presented in cycle e, nb_sel is 1 in cycles e+1 to e+RD_LAT-1 and 2 from cycle e+RD_LAT onward, for as long as the alert state lasts.
- R7: A good soft channel reset received while nb_sel is not 0 executes in the same cycle and returns nb_sel to 0 in the next cycle. Commands of any code execute after that.
- R8: A link fast reset pulse returns nb_sel to 0 in the next cycle. It has priority over entering the alert state and leaves the flags and the log untouched.
- R9: A further error while the alert state is active does not restart the slot count: alert frames continue without a gap.
- R10: After reset, cmd_exec, err_first, err_next, alert_stat, log_frame and nb_sel are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_valid | input | 1 | A decoded southbound frame is present this cycle |
| sb_frame | input | FRAME_W | Raw southbound frame bits |
| sb_crc_ok | input | 1 | Frame CRC checked good |
| sb_cmd | input | 2 | Command code: 0 no-op, 1 config read, 2 other, 3 soft channel reset |
| inj_alert | input | 1 | Software injection trigger for this frame |
| mask_crc_en | input | 1 | Enables CRC error handling |
| mask_inj_en | input | 1 | Enables injected alert handling |
| link_fast_rst | input | 1 | Link fast reset indication |
| err_clr | input | 1 | Clears error flags and status |
| cmd_exec | output | 1 | Execute the command of the current frame |
| log_frame | output | FRAME_W | Captured frame of the first error |
| err_first | output | 2 | First-error kinds |
| err_next | output | 2 | Subsequent-error kinds |
| alert_stat | output | 1 | Error/alert asserted status |
| nb_sel | output | 2 | Northbound frame selector |

## Verification
The bench builds the block with FRAME_W at 120 and RD_LAT at 4. This gives three idle slots before the first alert, so an early or late switch to alert frames shows up as a wrong selector value in a specific cycle. The full frame width lets the captured log be compared bit for bit against distinct patterns that reach both ends of the frame. A second error placed inside the alert window checks that the log holds and the slot count does not restart.

// File: rtl/lnk_alert_pkg.sv
package lnk_alert_pkg;
  localparam int ERR_W   = 2;
  localparam int ERR_CRC = 0;
  localparam int ERR_INJ = 1;

  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_CFG_RD = 2'd1,
    CMD_OTHER  = 2'd2,
    CMD_SRST   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    NB_NORMAL = 2'd0,
    NB_IDLE   = 2'd1,
    NB_ALERT  = 2'd2
  } nb_e;
endpackage

// File: rtl/lnk_alert_filter.sv
module lnk_alert_filter
  import lnk_alert_pkg::*;
(
  input  logic             sb_valid,
  input  logic             sb_crc_ok,
  input  logic [1:0]       sb_cmd,
  input  logic             inj_alert,
  input  logic             mask_crc_en,
  input  logic             mask_inj_en,
  input  logic             filt_on,
  output logic [ERR_W-1:0] err_kind,
  output logic             err_hit,
  output logic             exec_ok,
  output logic             srst_ok
);
  logic good;
  logic is_srst;

  always_comb begin
    err_kind          = '0;
    err_kind[ERR_CRC] = sb_valid & ~sb_crc_ok & mask_crc_en;
    err_kind[ERR_INJ] = sb_valid & inj_alert & mask_inj_en;
    err_hit           = |err_kind;
    // bad CRC never executes, masked or not
    good              = sb_valid & sb_crc_ok & ~err_kind[ERR_INJ];
    is_srst           = (sb_cmd == CMD_SRST);
    srst_ok           = good & is_srst;
    exec_ok           = good & (~filt_on | is_srst);
  end
endmodule

// File: rtl/lnk_alert_seq.sv
module lnk_alert_seq
  import lnk_alert_pkg::*;
#(
  parameter int RD_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_hit,
  input  logic       srst_ok,
  input  logic       link_fast_rst,
  output logic [1:0] nb_sel,
  output logic       filt_on
);
  localparam int CNT_W = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RD_LAT - 1);

  nb_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (link_fast_rst || srst_ok) begin
      st_d = NB_NORMAL;
    end else begin
      unique case (st_q)
        NB_NORMAL: if (err_hit) begin
          st_d   = (RD_LAT <= 1) ? NB_ALERT : NB_IDLE;
          cnt_d  = CNT_INIT;
          cnt_en = 1'b1;
        end
        NB_IDLE: begin
          if (cnt_q <= CNT_W'(1)) st_d = NB_ALERT;
          cnt_d  = cnt_q - CNT_W'(1);
          cnt_en = 1'b1;
        end
        default: st_d = NB_ALERT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= NB_NORMAL;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign nb_sel  = st_q;
  assign filt_on = (st_q != NB_NORMAL);
endmodule

// File: rtl/lnk_alert_log.sv
module lnk_alert_log
  import lnk_alert_pkg::*;
#(
  parameter int FRAME_W = 120
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ERR_W-1:0]   err_kind,
  input  logic               err_hit,
  input  logic               err_clr,
  input  logic [FRAME_W-1:0] sb_frame,
  output logic [FRAME_W-1:0] log_frame,
  output logic [ERR_W-1:0]   err_first,
  output logic [ERR_W-1:0]   err_next,
  output logic               alert_stat
);
  logic [ERR_W-1:0]   first_q, first_d, next_q, next_d;
  logic               stat_q, stat_d;
  logic [FRAME_W-1:0] log_q;
  logic               log_en;

  always_comb begin
    first_d = err_clr ? '0 : first_q;
    next_d  = err_clr ? '0 : next_q;
    stat_d  = err_clr ? 1'b0 : stat_q;
    log_en  = 1'b0;
    if (err_hit) begin
      stat_d = 1'b1;
      if (first_d == '0) begin
        first_d = err_kind;
        log_en  = 1'b1;
      end else begin
        next_d  = next_d | err_kind;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
      stat_q  <= 1'b0;
      log_q   <= '0;
    end else begin
      first_q <= first_d;
      next_q  <= next_d;
      stat_q  <= stat_d;
      if (log_en) log_q <= sb_frame;
    end
  end

  assign log_frame  = log_q;
  assign err_first  = first_q;
  assign err_next   = next_q;
  assign alert_stat = stat_q;
endmodule

// File: rtl/lnk_alert_ctl.sv
module lnk_alert_ctl
  import lnk_alert_pkg::*;
#(
  parameter int FRAME_W = 120,
  parameter int RD_LAT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sb_valid,
  input  logic [FRAME_W-1:0] sb_frame,
  input  logic               sb_crc_ok,
  input  logic [1:0]         sb_cmd,
  input  logic               inj_alert,
  input  logic               mask_crc_en,
  input  logic               mask_inj_en,
  input  logic               link_fast_rst,
  input  logic               err_clr,
  output logic               cmd_exec,
  output logic [FRAME_W-1:0] log_frame,
  output logic [1:0]         err_first,
  output logic [1:0]         err_next,
  output logic               alert_stat,
  output logic [1:0]         nb_sel
);
  logic [ERR_W-1:0] err_kind;
  logic             err_hit, srst_ok, filt_on;

  lnk_alert_filter u_filt (
    .sb_valid    (sb_valid),
    .sb_crc_ok   (sb_crc_ok),
    .sb_cmd      (sb_cmd),
    .inj_alert   (inj_alert),
    .mask_crc_en (mask_crc_en),
    .mask_inj_en (mask_inj_en),
    .filt_on     (filt_on),
    .err_kind    (err_kind),
    .err_hit     (err_hit),
    .exec_ok     (cmd_exec),
    .srst_ok     (srst_ok)
  );

  lnk_alert_seq #(.RD_LAT(RD_LAT)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_hit       (err_hit),
    .srst_ok       (srst_ok),
    .link_fast_rst (link_fast_rst),
    .nb_sel        (nb_sel),
    .filt_on       (filt_on)
  );

  lnk_alert_log #(.FRAME_W(FRAME_W)) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_kind   (err_kind),
    .err_hit    (err_hit),
    .err_clr    (err_clr),
    .sb_frame   (sb_frame),
    .log_frame  (log_frame),
    .err_first  (err_first),
    .err_next   (err_next),
    .alert_stat (alert_stat)
  );
endmodule

// File: rtl/lnk_alert_chk.sv
module lnk_alert_chk #(
  parameter int FRAME_W = 120
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sb_valid,
  input logic               sb_crc_ok,
  input logic [1:0]         sb_cmd,
  input logic               inj_alert,
  input logic               mask_crc_en,
  input logic               mask_inj_en,
  input logic               link_fast_rst,
  input logic               err_clr,
  input logic               cmd_exec,
  input logic [FRAME_W-1:0] log_frame,
  input logic [1:0]         err_first,
  input logic [1:0]         nb_sel
);
  logic bad_in;
  assign bad_in = sb_valid && ((!sb_crc_ok && mask_crc_en) || (inj_alert && mask_inj_en));

  p_mask_off_exec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && sb_crc_ok && inj_alert && !mask_inj_en && nb_sel == 2'd0) |-> cmd_exec);

  p_bad_crc_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && !sb_crc_ok) |-> !cmd_exec);

  p_log_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_first != 2'd0) && !err_clr) |=> $stable(log_frame));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_in |=> (err_first != 2'd0));

  p_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((nb_sel != 2'd0) && sb_cmd != 2'd3) |-> !cmd_exec);

  p_alert_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nb_sel == 2'd2 && !link_fast_rst && !(cmd_exec && sb_cmd == 2'd3)) |=> nb_sel == 2'd2);

  p_srst_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((nb_sel != 2'd0) && cmd_exec && sb_cmd == 2'd3) |=> nb_sel == 2'd0);

  p_lfr_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_fast_rst |=> nb_sel == 2'd0);
endmodule

bind lnk_alert_ctl lnk_alert_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sb_valid      (sb_valid),
  .sb_crc_ok     (sb_crc_ok),
  .sb_cmd        (sb_cmd),
  .inj_alert     (inj_alert),
  .mask_crc_en   (mask_crc_en),
  .mask_inj_en   (mask_inj_en),
  .link_fast_rst (link_fast_rst),
  .err_clr       (err_clr),
  .cmd_exec      (cmd_exec),
  .log_frame     (log_frame),
  .err_first     (err_first),
  .nb_sel        (nb_sel)
);

// File: tb/sim_lnk_alert_ctl.sv
module sim_lnk_alert_ctl;
  localparam int FW  = 120;
  localparam int LAT = 4;

  logic          clk, rst_n;
  logic          sb_valid, sb_crc_ok, inj_alert, mask_crc_en, mask_inj_en;
  logic          link_fast_rst, err_clr;
  logic [FW-1:0] sb_frame;
  logic [1:0]    sb_cmd;
  logic          cmd_exec, alert_stat;
  logic [FW-1:0] log_frame;
  logic [1:0]    err_first, err_next, nb_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  lnk_alert_ctl #(.FRAME_W(FW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .sb_valid(sb_valid), .sb_frame(sb_frame),
    .sb_crc_ok(sb_crc_ok), .sb_cmd(sb_cmd), .inj_alert(inj_alert),
    .mask_crc_en(mask_crc_en), .mask_inj_en(mask_inj_en),
    .link_fast_rst(link_fast_rst), .err_clr(err_clr), .cmd_exec(cmd_exec),
    .log_frame(log_frame), .err_first(err_first), .err_next(err_next),
    .alert_stat(alert_stat), .nb_sel(nb_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam logic [FW-1:0] F1 = {4'hA, 112'h0123_4567_89AB_CDEF_FEDC_BA98_7654, 4'h5};
  localparam logic [FW-1:0] F2 = {FW{1'b1}};
  localparam logic [FW-1:0] F3 = {4'h8, 112'h0, 4'h1};

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present one frame slot: drive at negedge, settle before sampling
  task automatic step(input logic v, input logic crc, input logic [1:0] cmd,
                      input logic inj, input logic lfr, input logic clr,
                      input logic [FW-1:0] fr);
    @(negedge clk);
    sb_valid = v; sb_crc_ok = crc; sb_cmd = cmd; inj_alert = inj;
    link_fast_rst = lfr; err_clr = clr; sb_frame = fr;
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_reset();
    chk("R10 cmd_exec", cmd_exec, 0);
    chk("R10 err_first", err_first, 0);
    chk("R10 err_next", err_next, 0);
    chk("R10 alert_stat", alert_stat, 0);
    chk("R10 log_frame", log_frame, 0);
    chk("R10 nb_sel", nb_sel, 0);
  endtask

  task automatic t_inj_masked();
    mask_inj_en = 1'b0;
    step(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, F3);
    chk("R1 masked injection executes", cmd_exec, 1);
    idle();
    chk("R1 masked injection no flag", err_first, 0);
    chk("R1 masked injection no alert", nb_sel, 0);
  endtask

  task automatic t_crc_alert();
    step(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, F1);
    chk("R2 bad CRC not executed", cmd_exec, 0);
    idle();
    chk("R3 log captured", log_frame, F1);
    chk("R4 first error CRC", err_first, 2'b01);
    chk("R4 alert status", alert_stat, 1);
    chk("R6 idle slot 1", nb_sel, 1);
    idle();
    chk("R6 idle slot 2", nb_sel, 1);
    idle();
    chk("R6 idle slot 3", nb_sel, 1);
    idle();
    chk("R6 first alert slot", nb_sel, 2);
    step(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, F3);
    chk("R5 other cmd blocked", cmd_exec, 0);
    chk("R6 alert continues", nb_sel, 2);
    step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, F3);
    chk("R5 config read blocked", cmd_exec, 0);
    step(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, F2);
    chk("R2 second bad CRC blocked", cmd_exec, 0);
    idle();
    chk("R4 next error CRC", err_next, 2'b01);
    chk("R3 log not overwritten", log_frame, F1);
    chk("R9 alert not restarted", nb_sel, 2);
    step(1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, F3);
    chk("R7 soft reset executes", cmd_exec, 1);
    step(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, F3);
    chk("R7 normal after soft reset", nb_sel, 0);
    chk("R7 command executes again", cmd_exec, 1);
    step(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, '0);
    idle();
    chk("R4 clear first", err_first, 0);
    chk("R4 clear next", err_next, 0);
    chk("R4 clear status", alert_stat, 0);
  endtask

  task automatic t_inj_lfr();
    mask_inj_en = 1'b1;
    step(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, F3);
    chk("R1 enabled injection blocks", cmd_exec, 0);
    idle();
    chk("R4 first error injected", err_first, 2'b10);
    chk("R3 injected log", log_frame, F3);
    chk("R1 injected enters idle", nb_sel, 1);
    step(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, '0);
    idle();
    chk("R8 fast reset exits", nb_sel, 0);
    chk("R8 flags kept", err_first, 2'b10);
    chk("R8 log kept", log_frame, F3);
    repeat (LAT + 1) idle();
    chk("R8 no alert later", nb_sel, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sb_valid = 0; sb_crc_ok = 1; sb_cmd = 0; inj_alert = 0;
    mask_crc_en = 1; mask_inj_en = 0; link_fast_rst = 0; err_clr = 0;
    sb_frame = '0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_inj_masked();
    t_crc_alert();
    t_inj_lfr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule